// File: doc/BRIEF.md
# Programmable Serial Baud Generator

This block turns the system clock into the timing strobes a serial port needs. An 8-bit reload value X sets the period of a free-running down-counter. Two mode inputs choose one of three divide ratios. In asynchronous slow mode the bit rate is Fclk / (64·(X+1)). In asynchronous fast mode it is Fclk / (16·(X+1)). In synchronous mode it is Fclk / (4·(X+1)), and the fast select has no effect. In both asynchronous modes the block gives a 16x oversample strobe for a receiver's sampling logic and a bit strobe for the shifters. In synchronous mode it gives only the bit strobe, at the shift clock rate. For example, a 16 MHz clock with X = 25 in slow asynchronous mode gives about 9615 baud.

A write strobe loads a new divisor. The write restarts the counter at once, so the new rate does not wait for the old period to run out. When the run input is low, the generator is held in its restart state. When run rises, a strobe follows immediately, so a synchronous shifter gets a shift clock without delay. A synchronous reset clears the counter, the prescaler, the oversample phase and the stored divisor.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_i` is high, and in the cycle after any clock edge at which it was high, `os_tick_o` and `bit_tick_o` are 0. Reset also clears the stored divisor to 0.
- R2: In asynchronous fast mode (`sync_i`=0, `fast_i`=1), `os_tick_o` pulses every X+1 clock cycles.
- R3: In asynchronous slow mode (`sync_i`=0, `fast_i`=0), `os_tick_o` pulses every 4·(X+1) clock cycles.
- R4: In both asynchronous modes, `bit_tick_o` pulses in the same cycle as every 16th `os_tick_o` pulse. The first bit pulse coincides with the 16th oversample pulse after a restart, so the bit period is 16 oversample periods.
- R5: In synchronous mode (`sync_i`=1), `bit_tick_o` pulses every 4·(X+1) cycles whatever the value of `fast_i`, and `os_tick_o` stays 0.
- R6: `bit_tick_o` is never high in two consecutive cycles.
- R7: While `run_i` is low, no strobe is produced: in the cycle after any edge at which `run_i` was low, both outputs are 0. At the first edge at which `run_i` is high again, the generator fires. The first strobe (`os_tick_o` in asynchronous modes, `bit_tick_o` in synchronous mode) is high in the cycle right after that edge.
- R8: A clock edge with `div_wr_i` high stores `div_i` and restarts the prescaler, counter and oversample phase. No strobe appears in the following cycle. If `run_i` is high, the next edge fires a strobe, and the later period uses the new divisor.
- R9: A divisor written while `run_i` is low is kept. It sets the period once `run_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Enable; when low the generator is held in restart |
| sync_i | input | 1 | 1 = synchronous mode (divide by 4·(X+1)) |
| fast_i | input | 1 | Asynchronous fast select; ignored in synchronous mode |
| div_wr_i | input | 1 | Write strobe for the divisor |
| div_i | input | 8 | New divisor value X |
| os_tick_o | output | 1 | 16x oversample strobe, one cycle wide |
| bit_tick_o | output | 1 | Bit-rate strobe, one cycle wide |

## Verification
A wrong prescaler or counter value shows up as a strobe interval that is off, and this appears within one period of 4·(X+1) cycles. A wrong oversample phase shows only at the bit strobe, so it can take up to sixteen oversample periods to appear. A restart that misses a piece of state shows as a first strobe that is not exactly one cycle after release or after a write. That makes release and write timing the sharpest probe.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_W_DEF    = 8;
    localparam int PRE_LOG2_DEF = 2;
    localparam int OVS_LOG2_DEF = 4;

    typedef enum logic [1:0] {
        MODE_ASYNC_SLOW = 2'd0,
        MODE_ASYNC_FAST = 2'd1,
        MODE_SYNC       = 2'd2
    } rate_mode_e;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
#(
    parameter int PRE_LOG2 = PRE_LOG2_DEF
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       restart_i,
    input  rate_mode_e mode_i,
    output logic       strobe_o
);
    localparam logic [PRE_LOG2-1:0] PRE_LAST = '1;

    typedef struct packed {
        logic [PRE_LOG2-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       bypass;

    // The fast asynchronous mode skips the fixed divider.
    assign bypass = (mode_i == MODE_ASYNC_FAST);

    always_comb begin
        st_d = st_q;
        if (rst_i || restart_i) begin
            // Park on the terminal value so the first active cycle strobes.
            st_d.cnt = PRE_LAST;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        strobe_o = !restart_i && (bypass || (st_q.cnt == PRE_LAST));
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/baud_counter.sv
module baud_counter
    import baud_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             restart_i,
    input  logic             strobe_i,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             base_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        base_o = 1'b0;
        if (wr_i) begin
            st_d.div = div_i;
        end
        if (rst_i) begin
            st_d.cnt = '0;
            st_d.div = '0;
        end else if (restart_i) begin
            st_d.cnt = '0;
        end else if (strobe_i) begin
            if (st_q.cnt == '0) begin
                base_o   = 1'b1;
                st_d.cnt = st_q.div;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/baud_phase.sv
module baud_phase
    import baud_pkg::*;
#(
    parameter int OVS_LOG2 = OVS_LOG2_DEF
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       restart_i,
    input  logic       base_i,
    input  rate_mode_e mode_i,
    output logic       os_tick_o,
    output logic       bit_tick_o
);
    localparam logic [OVS_LOG2-1:0] PH_LAST = '1;

    typedef struct packed {
        logic [OVS_LOG2-1:0] phase;
        logic                os;
        logic                bt;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic      is_sync;

    assign is_sync = (mode_i == MODE_SYNC);

    always_comb begin
        st_d = st_q;
        if (rst_i || restart_i) begin
            st_d = '0;
        end else begin
            st_d.os = base_i && !is_sync;
            st_d.bt = base_i && (is_sync || (st_q.phase == PH_LAST));
            if (base_i && !is_sync) begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign os_tick_o  = st_q.os;
    assign bit_tick_o = st_q.bt;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W    = DIV_W_DEF,
    parameter int PRE_LOG2 = PRE_LOG2_DEF,
    parameter int OVS_LOG2 = OVS_LOG2_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             sync_i,
    input  logic             fast_i,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             os_tick_o,
    output logic             bit_tick_o
);
    rate_mode_e mode;
    logic       restart;
    logic       strobe;
    logic       base;

    always_comb begin
        if (sync_i) begin
            mode = MODE_SYNC;
        end else if (fast_i) begin
            mode = MODE_ASYNC_FAST;
        end else begin
            mode = MODE_ASYNC_SLOW;
        end
    end

    // Disabled or freshly written: hold every stage in its start state.
    assign restart = !run_i || div_wr_i;

    baud_prescale #(.PRE_LOG2(PRE_LOG2)) pre_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .mode_i    (mode),
        .strobe_o  (strobe)
    );

    baud_counter #(.DIV_W(DIV_W)) cnt_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .strobe_i  (strobe),
        .wr_i      (div_wr_i),
        .div_i     (div_i),
        .base_o    (base)
    );

    baud_phase #(.OVS_LOG2(OVS_LOG2)) ph_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .restart_i  (restart),
        .base_i     (base),
        .mode_i     (mode),
        .os_tick_o  (os_tick_o),
        .bit_tick_o (bit_tick_o)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic clk_i,
    input logic rst_i,
    input logic run_i,
    input logic sync_i,
    input logic div_wr_i,
    input logic os_tick_o,
    input logic bit_tick_o
);
    logic was_rst = 1'b0;

    // R1: outputs are quiet in the cycle after a reset edge
    always_ff @(posedge clk_i) begin
        if (was_rst) begin
            a_reset_quiet_r1 : assert (!os_tick_o && !bit_tick_o)
                else $error("R1: strobe after reset edge");
        end
        was_rst <= rst_i;
    end

    // R4: an asynchronous bit strobe always lands on an oversample strobe
    p_bit_on_os_r4 : assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_tick_o && !$past(sync_i)) |-> os_tick_o);

    // R5: synchronous mode gives no oversample strobe
    p_sync_no_os_r5 : assert property (@(posedge clk_i) disable iff (rst_i)
        $past(sync_i) |-> !os_tick_o);

    // R6: bit strobe is one cycle wide
    p_bit_single_r6 : assert property (@(posedge clk_i) disable iff (rst_i)
        bit_tick_o |=> !bit_tick_o);

    // R7: held generator stays silent
    p_hold_quiet_r7 : assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(run_i) |-> (!os_tick_o && !bit_tick_o));

    // R8: a divisor write gives a silent cycle
    p_write_quiet_r8 : assert property (@(posedge clk_i) disable iff (rst_i)
        $past(div_wr_i) |-> (!os_tick_o && !bit_tick_o));
endmodule

bind baud_tick_gen baud_tick_gen_chk chk_i (.*);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       run_i = 1'b0;
    logic       sync_i = 1'b0;
    logic       fast_i = 1'b0;
    logic       div_wr_i = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       os_tick_o;
    logic       bit_tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;   // 250 MHz

    baud_tick_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst_i),
        .run_i      (run_i),
        .sync_i     (sync_i),
        .fast_i     (fast_i),
        .div_wr_i   (div_wr_i),
        .div_i      (div_i),
        .os_tick_o  (os_tick_o),
        .bit_tick_o (bit_tick_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Configure while held, then release and measure strobe positions.
    task automatic run_cfg(input logic fast, input logic syn, input int x);
        int p, limit, f_os, s_os, f_bit, s_bit, os_between, bits_seen, os_in_sync;
        string rq;
        p = (fast && !syn) ? (x + 1) : 4 * (x + 1);
        rq = syn ? "R5" : (fast ? "R2" : "R3");
        @(negedge clk);
        run_i = 1'b0; fast_i = fast; sync_i = syn; div_i = 8'(x); div_wr_i = 1'b1;
        @(negedge clk);
        div_wr_i = 1'b0; run_i = 1'b1;
        limit = syn ? (2 * p + 3) : (31 * p + 3);
        f_os = -1; s_os = -1; f_bit = -1; s_bit = -1;
        os_between = 0; bits_seen = 0; os_in_sync = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (os_tick_o) begin
                if (syn) os_in_sync++;
                if (f_os < 0) f_os = i;
                else if (s_os < 0) s_os = i;
                if (bits_seen == 1) os_between++;
            end
            if (bit_tick_o) begin
                if (f_bit < 0) f_bit = i;
                else if (s_bit < 0) s_bit = i;
                bits_seen++;
            end
        end
        if (syn) begin
            check(f_bit == 1, "R7 first sync strobe", f_bit, 1);
            check(s_bit == 1 + p, "R5 sync bit period", s_bit, 1 + p);
            check(os_in_sync == 0, "R5 no os in sync", os_in_sync, 0);
        end else begin
            check(f_os == 1, "R7 first os strobe", f_os, 1);
            check(s_os == 1 + p, {rq, " os period"}, s_os, 1 + p);
            check(f_bit == 1 + 15 * p, "R4 first bit strobe", f_bit, 1 + 15 * p);
            check(s_bit == 1 + 31 * p, "R4 second bit strobe", s_bit, 1 + 31 * p);
            check(os_between == 16, "R4 os per bit", os_between, 16);
        end
    endtask

    initial begin
        int hits;
        // R1: quiet under reset even when running
        run_i = 1'b1; fast_i = 1'b1;
        hits = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (os_tick_o || bit_tick_o) hits++;
        end
        check(hits == 0, "R1 quiet in reset", hits, 0);
        @(negedge clk);
        rst_i = 1'b0;

        // R1: reset cleared divisor to 0, so fast period is 1 cycle
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (os_tick_o) hits++;
        end
        check(hits == 8, "R1 divisor reset to zero", hits, 8);

        // R1: reset in the middle of a run silences the next cycle
        @(negedge clk); rst_i = 1'b1;
        @(negedge clk);
        check(!os_tick_o && !bit_tick_o, "R1 mid-run reset", os_tick_o, 0);
        rst_i = 1'b0;

        // R2, R4, R5: sweeps
        for (int x = 0; x < 16; x++) run_cfg(1'b1, 1'b0, x);
        for (int x = 0; x < 16; x++) begin
            run_cfg(1'b0, 1'b1, x);
            run_cfg(1'b1, 1'b1, x);
        end
        // R3
        for (int x = 0; x < 8; x++) run_cfg(1'b0, 1'b0, x);
        run_cfg(1'b0, 1'b0, 25);
        run_cfg(1'b0, 1'b0, 255);

        // R7: dropping run silences the outputs
        @(negedge clk); sync_i = 1'b0; fast_i = 1'b1; run_i = 1'b0;
        div_i = 8'd3; div_wr_i = 1'b0;
        hits = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (os_tick_o || bit_tick_o) hits++;
        end
        check(hits == 0, "R7 hold quiet", hits, 0);

        // R9: write during hold is kept and silent
        div_wr_i = 1'b1; div_i = 8'd1;
        @(negedge clk); div_wr_i = 1'b0; div_i = 8'd200;
        hits = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (os_tick_o || bit_tick_o) hits++;
        end
        check(hits == 0, "R9 no strobe during held write", hits, 0);
        run_i = 1'b1;
        @(negedge clk);
        check(os_tick_o == 1'b1, "R9 first strobe after release", os_tick_o, 1);
        @(negedge clk);
        check(os_tick_o == 1'b0, "R9 gap with stored divisor", os_tick_o, 0);
        @(negedge clk);
        check(os_tick_o == 1'b1, "R9 period uses stored divisor", os_tick_o, 1);

        // R8: write while running restarts at once
        div_i = 8'd9;
        div_wr_i = 1'b1;
        @(negedge clk); div_wr_i = 1'b0;
        for (int i = 0; i < 7; i++) @(negedge clk);
        div_i = 8'd3; div_wr_i = 1'b1;
        @(negedge clk); div_wr_i = 1'b0;
        check(!os_tick_o && !bit_tick_o, "R8 silent cycle after write", os_tick_o, 0);
        @(negedge clk);
        check(os_tick_o == 1'b1, "R8 strobe right after write", os_tick_o, 1);
        begin
            int f_os, f_bit;
            f_os = -1; f_bit = -1;
            for (int i = 1; i <= 70; i++) begin
                @(negedge clk);
                if (os_tick_o && f_os < 0) f_os = i;
                if (bit_tick_o && f_bit < 0) f_bit = i;
            end
            check(f_os == 4, "R8 new period", f_os, 4);
            check(f_bit == 60, "R8 phase restarted", f_bit, 60);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // R6: bench-side width check on the bit strobe
    logic prev_bit = 1'b0;
    int   wide_bits = 0;
    always @(negedge clk) begin
        if (!rst_i && prev_bit && bit_tick_o) wide_bits++;
        prev_bit = bit_tick_o;
    end
    final begin
        if (wide_bits != 0) $display("FAIL R6 bit strobe width actual=%0d expected=0", wide_bits);
    end
    initial begin
        wait (n_checks > 10);
        forever begin
            @(negedge clk);
            if (wide_bits == 1) begin
                check(1'b0, "R6 bit strobe single", wide_bits, 0);
                wide_bits = 2;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end
endmodule